// File: doc/BRIEF.md
# Paged Command and Interrupt Register Front End

This block is the host-side register file of a small Ethernet controller. A host reaches it through byte-wide reads and writes at a 4-bit I/O offset. The command register holds a page number in its top two bits. Each offset is combined with that page to select a register. The command register appears at offset 0 on every page, so software can always change page.

The block holds the command, transmit start page, transmit byte count, interrupt status and interrupt mask registers. It also holds six station-address bytes and eight multicast-filter bytes as plain storage. One level interrupt output reports any status bit that is enabled in the mask. A command write with the transmit bit launches a request to an external transmit engine. The request carries a start address and a length, and its completion is recorded in a transmit status register. Receive and remote-DMA logic connect only through event strobes that set status bits.

A two-state machine follows each transmit. From `TX_IDLE` the transition *launch* moves it to `TX_BUSY`; it fires when a command write carries the transmit bit. From `TX_BUSY` the transition *complete* returns it to `TX_IDLE`; it fires on the engine's acknowledge. There are no other transitions.

Top module: `nic_paged_regs`

## Requirements
- R1: After reset the command register reads 0x21 (stop plus no-DMA, page 0). Interrupt status reads 0x80, the mask is 0x00 and `irq` is low.
- R2: The register index is `{page, bus_offset}`, with page taken from command bits 7:6. Offset 0 reads and writes the command register on every page. On page 0, offsets 4, 5, 6 and 15 write the transmit start page, count low byte, count high byte and mask. On page 2 the same offsets read those registers back.
- R3: A write to page 0 offset 7 clears each status bit 6:0 whose written bit is 1. Bit 7 is unaffected by such writes. Reads return the status.
- R4: A command write with bit 1 (start) set clears status bit 7. Nothing else sets bit 7 except reset.
- R5: `irq` is high exactly when status AND mask is nonzero. It follows a change from the same clock edge that made the change.
- R6: The 16-bit transmit count is written as two bytes. Each write replaces only its own half.
- R7: A command write with bit 2 (transmit) set in `TX_IDLE` raises `tx_req` from the next edge. With it, `tx_addr` = start page × 256 and `tx_len` = the transmit count. Command bit 2 reads 1 while busy.
- R8: `tx_ack` in `TX_BUSY` drops `tx_req` at that edge. If `tx_err` is low it sets status bit 1 and transmit status (page 0 offset 4 read) becomes 0x01. If `tx_err` is high it sets status bit 3 and transmit status becomes 0x08. Command bit 2 then reads 0.
- R9: While busy, a transmit command or a rewrite of start page or count leaves `tx_req`, `tx_addr` and `tx_len` unchanged.
- R10: Bit n of `evt_set` (n = 0..6) sets status bit n. A set wins over a same-cycle clear.
- R11: On page 3 every offset other than 0 reads 0x00 and ignores writes.
- R12: On page 1, offsets 1 to 6 hold the station address and offsets 8 to 15 the multicast filter. Each byte reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Host access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_offset | input | 4 | I/O offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from offset and page |
| evt_set | input | 7 | One-cycle strobes setting status bits 6:0 |
| tx_req | output | 1 | Transmit request, held until acknowledge |
| tx_addr | output | 16 | Frame start address (start page × 256) |
| tx_len | output | 16 | Frame length in bytes |
| tx_ack | input | 1 | Transmit engine completion strobe |
| tx_err | input | 1 | Completion was in error (valid with `tx_ack`) |
| irq | output | 1 | Level interrupt |

## Verification
A wrong page value in the command register shows on the first read after the page change. Such a read returns a neighbouring page's register or zero. A status bit left set or cleared by mistake shows through `irq` in the cycle after the edge, provided the mask enables that bit. It also shows on the next read of offset 7. A transmit state machine stuck in `TX_BUSY` keeps `tx_req` high and command bit 2 set after the acknowledge. A stale launch snapshot shows as a wrong `tx_addr` or `tx_len` in the first cycle of the next request.

// File: rtl/nic_regs_pkg.sv
package nic_regs_pkg;
    localparam int DATA_W  = 8;
    localparam int OFS_W   = 4;
    localparam int PAGE_W  = 2;
    localparam int IDX_W   = OFS_W + PAGE_W;
    localparam int EVT_W   = 7;

    localparam int CMD_START_B = 1;
    localparam int CMD_TX_B    = 2;
    localparam int ST_TX_OK_B  = 1;
    localparam int ST_TX_ERR_B = 3;
    localparam int ST_RESET_B  = 7;

    localparam logic [DATA_W-1:0] CMD_RST_VAL = 8'h21;
    localparam logic [DATA_W-1:0] ST_RST_VAL  = 8'h80;
    localparam logic [DATA_W-1:0] TXS_GOOD    = 8'h01;
    localparam logic [DATA_W-1:0] TXS_ABORT   = 8'h08;

    localparam logic [IDX_W-1:0] IX_TXPG_W  = 6'h04;
    localparam logic [IDX_W-1:0] IX_CNTLO_W = 6'h05;
    localparam logic [IDX_W-1:0] IX_CNTHI_W = 6'h06;
    localparam logic [IDX_W-1:0] IX_STATUS  = 6'h07;
    localparam logic [IDX_W-1:0] IX_MASK_W  = 6'h0F;
    localparam logic [IDX_W-1:0] IX_TXPG_R  = 6'h24;
    localparam logic [IDX_W-1:0] IX_CNTLO_R = 6'h25;
    localparam logic [IDX_W-1:0] IX_CNTHI_R = 6'h26;
    localparam logic [IDX_W-1:0] IX_MASK_R  = 6'h2F;

    typedef enum logic [0:0] {TX_IDLE, TX_BUSY} tx_state_e;
endpackage

// File: rtl/nic_status_unit.sv
module nic_status_unit
    import nic_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_we,
    input  logic [DATA_W-1:0] clr_bits,
    input  logic              start_seen,
    input  logic [DATA_W-1:0] set_bits,
    input  logic              mask_we,
    input  logic [DATA_W-1:0] mask_data,
    output logic [DATA_W-1:0] status,
    output logic [DATA_W-1:0] mask,
    output logic              irq
);
    logic [DATA_W-1:0] status_n;

    always_comb begin
        status_n = status;
        if (clr_we) begin
            status_n[ST_RESET_B-1:0] = status[ST_RESET_B-1:0] & ~clr_bits[ST_RESET_B-1:0];
        end
        if (start_seen) begin
            status_n[ST_RESET_B] = 1'b0;
        end
        status_n = status_n | set_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= ST_RST_VAL;
            mask   <= '0;
        end else begin
            status <= status_n;
            if (mask_we) mask <= mask_data;
        end
    end

    assign irq = |(status & mask);
endmodule

// File: rtl/nic_tx_ctrl.sv
module nic_tx_ctrl
    import nic_regs_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                launch,
    input  logic [DATA_W-1:0]   start_page,
    input  logic [2*DATA_W-1:0] byte_count,
    input  logic                tx_ack,
    input  logic                tx_err,
    output logic                tx_req,
    output logic [2*DATA_W-1:0] tx_addr,
    output logic [2*DATA_W-1:0] tx_len,
    output logic                busy,
    output logic                done_ok,
    output logic                done_err,
    output logic [DATA_W-1:0]   tx_status
);
    tx_state_e state_q, state_n;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            TX_IDLE: if (launch) state_n = TX_BUSY;
            TX_BUSY: if (tx_ack) state_n = TX_IDLE;
            default: state_n = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= TX_IDLE;
            tx_addr   <= '0;
            tx_len    <= '0;
            tx_status <= '0;
        end else begin
            state_q <= state_n;
            if (state_q == TX_IDLE && launch) begin
                tx_addr <= {start_page, {DATA_W{1'b0}}};
                tx_len  <= byte_count;
            end
            if (state_q == TX_BUSY && tx_ack) begin
                tx_status <= tx_err ? TXS_ABORT : TXS_GOOD;
            end
        end
    end

    always_comb begin
        tx_req   = 1'b0;
        busy     = 1'b0;
        done_ok  = 1'b0;
        done_err = 1'b0;
        unique case (state_q)
            TX_IDLE: ;
            TX_BUSY: begin
                tx_req   = 1'b1;
                busy     = 1'b1;
                done_ok  = tx_ack & ~tx_err;
                done_err = tx_ack & tx_err;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/nic_byte_store.sv
module nic_byte_store
    import nic_regs_pkg::*;
#(
    parameter int NBYTES = 6,
    localparam int SEL_W = $clog2(NBYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SEL_W-1:0]  wsel,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SEL_W-1:0]  rsel,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] bytes_q [NBYTES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NBYTES; i++) bytes_q[i] <= '0;
        end else if (we) begin
            for (int i = 0; i < NBYTES; i++) begin
                if (wsel == SEL_W'(i)) bytes_q[i] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if (rsel == SEL_W'(i)) rdata = bytes_q[i];
        end
    end
endmodule

// File: rtl/nic_paged_regs.sv
module nic_paged_regs
    import nic_regs_pkg::*;
#(
    parameter int STATION_N = 6,
    parameter int FILTER_N  = 8,
    localparam int ST_SEL_W = $clog2(STATION_N),
    localparam int FL_SEL_W = $clog2(FILTER_N)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [OFS_W-1:0]    bus_offset,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [EVT_W-1:0]    evt_set,
    output logic                tx_req,
    output logic [2*DATA_W-1:0] tx_addr,
    output logic [2*DATA_W-1:0] tx_len,
    input  logic                tx_ack,
    input  logic                tx_err,
    output logic                irq
);
    logic [DATA_W-1:0]   cmd_q;
    logic [DATA_W-1:0]   txpg_q;
    logic [2*DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0]   status_w, mask_w, txs_w, st_rd, fl_rd, cmd_view;
    logic [PAGE_W-1:0]   page;
    logic [IDX_W-1:0]    idx;
    logic                wr_en, cmd_wr, busy, done_ok, done_err;
    logic                st_hit, fl_hit;
    logic [OFS_W-1:0]    st_ofs;
    logic [DATA_W-1:0]   set_bits;

    assign page   = cmd_q[DATA_W-1 -: PAGE_W];
    assign idx    = {page, bus_offset};
    assign wr_en  = bus_sel & bus_wr;
    assign cmd_wr = wr_en && (bus_offset == '0);
    assign st_ofs = bus_offset - OFS_W'(1);
    assign st_hit = (page == PAGE_W'(1)) && (bus_offset != '0)
                    && (st_ofs < OFS_W'(STATION_N));
    assign fl_hit = (page == PAGE_W'(1)) && bus_offset[OFS_W-1];
    assign cmd_view = cmd_q | (DATA_W'(busy) << CMD_TX_B);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q  <= CMD_RST_VAL;
            txpg_q <= '0;
            cnt_q  <= '0;
        end else if (wr_en) begin
            if (cmd_wr) cmd_q <= bus_wdata & ~(DATA_W'(1) << CMD_TX_B);
            if (idx == IX_TXPG_W)  txpg_q <= bus_wdata;
            if (idx == IX_CNTLO_W) cnt_q[DATA_W-1:0] <= bus_wdata;
            if (idx == IX_CNTHI_W) cnt_q[2*DATA_W-1:DATA_W] <= bus_wdata;
        end
    end

    assign set_bits = {1'b0, evt_set}
                    | (DATA_W'(done_ok)  << ST_TX_OK_B)
                    | (DATA_W'(done_err) << ST_TX_ERR_B);

    nic_status_unit u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_we     (wr_en && (idx == IX_STATUS)),
        .clr_bits   (bus_wdata),
        .start_seen (cmd_wr && bus_wdata[CMD_START_B]),
        .set_bits   (set_bits),
        .mask_we    (wr_en && (idx == IX_MASK_W)),
        .mask_data  (bus_wdata),
        .status     (status_w),
        .mask       (mask_w),
        .irq        (irq)
    );

    nic_tx_ctrl u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (cmd_wr && bus_wdata[CMD_TX_B]),
        .start_page (txpg_q),
        .byte_count (cnt_q),
        .tx_ack     (tx_ack),
        .tx_err     (tx_err),
        .tx_req     (tx_req),
        .tx_addr    (tx_addr),
        .tx_len     (tx_len),
        .busy       (busy),
        .done_ok    (done_ok),
        .done_err   (done_err),
        .tx_status  (txs_w)
    );

    nic_byte_store #(.NBYTES(STATION_N)) u_station (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en && st_hit),
        .wsel  (st_ofs[ST_SEL_W-1:0]),
        .wdata (bus_wdata),
        .rsel  (st_ofs[ST_SEL_W-1:0]),
        .rdata (st_rd)
    );

    nic_byte_store #(.NBYTES(FILTER_N)) u_filter (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en && fl_hit),
        .wsel  (bus_offset[FL_SEL_W-1:0]),
        .wdata (bus_wdata),
        .rsel  (bus_offset[FL_SEL_W-1:0]),
        .rdata (fl_rd)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_offset == '0) begin
            bus_rdata = cmd_view;
        end else if (st_hit) begin
            bus_rdata = st_rd;
        end else if (fl_hit) begin
            bus_rdata = fl_rd;
        end else begin
            case (idx)
                IX_TXPG_W:  bus_rdata = txs_w;
                IX_STATUS:  bus_rdata = status_w;
                IX_TXPG_R:  bus_rdata = txpg_q;
                IX_CNTLO_R: bus_rdata = cnt_q[DATA_W-1:0];
                IX_CNTHI_R: bus_rdata = cnt_q[2*DATA_W-1:DATA_W];
                IX_MASK_R:  bus_rdata = mask_w;
                default:    bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/nic_paged_regs_chk.sv
module nic_paged_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_sel,
    input logic        bus_wr,
    input logic [3:0]  bus_offset,
    input logic [7:0]  bus_wdata,
    input logic [6:0]  evt_set,
    input logic        tx_req,
    input logic [15:0] tx_addr,
    input logic [15:0] tx_len,
    input logic        tx_ack,
    input logic        tx_err,
    input logic [1:0]  page,
    input logic [7:0]  status,
    input logic [7:0]  mask
);
    logic wr_status;
    assign wr_status = bus_sel && bus_wr && (page == 2'd0) && (bus_offset == 4'd7);

    AST_TX_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n) tx_req && !tx_ack |=> tx_req); // R7
    AST_TX_SNAP_STABLE: assert property (@(posedge clk) disable iff (!rst_n) tx_req && !tx_ack |=> $stable(tx_addr) && $stable(tx_len)); // R9
    AST_TX_ACK_ENDS: assert property (@(posedge clk) disable iff (!rst_n) tx_req && tx_ack |=> !tx_req); // R8
    AST_TX_OK_FLAG: assert property (@(posedge clk) disable iff (!rst_n) tx_req && tx_ack && !tx_err |=> status[1]); // R8
    AST_RST_BIT_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n) !$rose(status[7])); // R4
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) bus_sel && bus_wr && bus_offset == 4'd0 && bus_wdata[1] |=> !status[7]); // R4
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) wr_status && bus_wdata[2] && !evt_set[2] |=> !status[2]); // R3
    AST_W1C_KEEPS_TOP: assert property (@(posedge clk) disable iff (!rst_n) wr_status && status[7] && !(bus_sel && bus_wr && bus_offset == 4'd0) |=> status[7]); // R3
    AST_PAGE3_NO_MASK: assert property (@(posedge clk) disable iff (!rst_n) bus_sel && bus_wr && page == 2'd3 && bus_offset != 4'd0 |=> $stable(mask)); // R11
    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n) evt_set != 7'd0 |=> (status[6:0] & $past(evt_set)) == $past(evt_set)); // R10
endmodule

bind nic_paged_regs nic_paged_regs_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_offset (bus_offset),
    .bus_wdata  (bus_wdata),
    .evt_set    (evt_set),
    .tx_req     (tx_req),
    .tx_addr    (tx_addr),
    .tx_len     (tx_len),
    .tx_ack     (tx_ack),
    .tx_err     (tx_err),
    .page       (cmd_q[7:6]),
    .status     (status_w),
    .mask       (mask_w)
);

// File: tb/nic_paged_regs_test.sv
module nic_paged_regs_test;
    localparam int K_RD = 0, K_IRQ = 1, K_REQ = 2, K_ADDR = 3, K_LEN = 4;

    typedef struct {
        int          kind;
        logic [15:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_offset = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [6:0]  evt_set = '0;
    logic        tx_req, tx_ack = 1'b0, tx_err = 1'b0, irq;
    logic [15:0] tx_addr, tx_len;

    item_t q[$];
    int n_checks = 0, n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    nic_paged_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_offset(bus_offset), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_set(evt_set), .tx_req(tx_req), .tx_addr(tx_addr), .tx_len(tx_len),
        .tx_ack(tx_ack), .tx_err(tx_err), .irq(irq)
    );

    // monitor: pops expected items and compares them with the ports
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0) begin
                item_t it;
                logic [15:0] act;
                it = q.pop_front();
                case (it.kind)
                    K_RD:    act = {8'h00, bus_rdata};
                    K_IRQ:   act = {15'd0, irq};
                    K_REQ:   act = {15'd0, tx_req};
                    K_ADDR:  act = tx_addr;
                    default: act = tx_len;
                endcase
                n_checks++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [3:0] ofs, input logic [7:0] d, input logic [6:0] ev = '0);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_offset = ofs; bus_wdata = d; evt_set = ev;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; evt_set = '0;
    endtask

    task automatic rd_chk(input logic [3:0] ofs, input logic [7:0] e, input string tag);
        item_t it;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_offset = ofs;
        it.kind = K_RD; it.exp = {8'h00, e}; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic port_chk(input int k, input logic [15:0] e, input string tag);
        item_t it;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        it.kind = k; it.exp = e; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic pulse_evt(input logic [6:0] ev);
        @(negedge clk);
        evt_set = ev;
        @(negedge clk);
        evt_set = '0;
    endtask

    task automatic ack(input logic e);
        @(negedge clk);
        tx_ack = 1'b1; tx_err = e;
        @(negedge clk);
        tx_ack = 1'b0; tx_err = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        rd_chk(4'h0, 8'h21, "R1 command reset");
        rd_chk(4'h7, 8'h80, "R1 status reset");
        port_chk(K_IRQ, 16'd0, "R1 irq reset");

        wr(4'hF, 8'h80);
        port_chk(K_IRQ, 16'd1, "R5 irq from reset bit");
        wr(4'h7, 8'hFF);
        rd_chk(4'h7, 8'h80, "R3 top bit not cleared by write");

        wr(4'h0, 8'h22);
        rd_chk(4'h7, 8'h00, "R4 start clears reset bit");
        port_chk(K_IRQ, 16'd0, "R5 irq drops");

        wr(4'h5, 8'h3C);
        wr(4'h6, 8'h01);
        wr(4'h4, 8'h40);
        wr(4'h0, 8'hA2);
        rd_chk(4'h5, 8'h3C, "R2 page2 count low");
        rd_chk(4'h6, 8'h01, "R2 page2 count high");
        rd_chk(4'h4, 8'h40, "R2 page2 start page");
        rd_chk(4'hF, 8'h80, "R2 page2 mask");
        wr(4'h0, 8'h22);
        wr(4'h6, 8'h02);
        wr(4'hF, 8'h02);

        wr(4'h0, 8'h26);
        port_chk(K_REQ, 16'd1, "R7 request raised");
        port_chk(K_ADDR, 16'h4000, "R7 address");
        port_chk(K_LEN, 16'h023C, "R6 R7 length high half replaced");
        rd_chk(4'h0, 8'h26, "R7 transmit bit while busy");

        wr(4'h4, 8'h10);
        wr(4'h0, 8'h26);
        port_chk(K_REQ, 16'd1, "R9 still requesting");
        port_chk(K_ADDR, 16'h4000, "R9 address unchanged");

        ack(1'b0);
        port_chk(K_REQ, 16'd0, "R8 request dropped");
        rd_chk(4'h7, 8'h02, "R8 tx ok status");
        rd_chk(4'h4, 8'h01, "R8 tx status good");
        rd_chk(4'h0, 8'h22, "R8 transmit bit cleared");
        port_chk(K_IRQ, 16'd1, "R5 irq on tx ok");
        wr(4'h7, 8'h02);
        port_chk(K_IRQ, 16'd0, "R3 R5 cleared tx ok");

        wr(4'h0, 8'h26);
        port_chk(K_ADDR, 16'h1000, "R7 second address");
        ack(1'b1);
        rd_chk(4'h7, 8'h08, "R8 tx error status");
        rd_chk(4'h4, 8'h08, "R8 tx status abort");
        port_chk(K_IRQ, 16'd0, "R5 masked error");

        pulse_evt(7'h41);
        rd_chk(4'h7, 8'h49, "R10 events set bits");
        wr(4'h7, 8'h01, 7'h01);
        rd_chk(4'h7, 8'h49, "R10 set wins over clear");

        wr(4'h0, 8'h62);
        rd_chk(4'h0, 8'h62, "R2 command on page1");
        wr(4'h1, 8'hAA);
        wr(4'h6, 8'h55);
        wr(4'h8, 8'h11);
        wr(4'hF, 8'h99);
        rd_chk(4'h1, 8'hAA, "R12 station first");
        rd_chk(4'h6, 8'h55, "R12 station last");
        rd_chk(4'h8, 8'h11, "R12 filter first");
        rd_chk(4'hF, 8'h99, "R12 filter last");

        wr(4'h0, 8'hE2);
        rd_chk(4'h0, 8'hE2, "R2 command on page3");
        wr(4'h7, 8'hFF);
        wr(4'hF, 8'h00);
        rd_chk(4'h7, 8'h00, "R11 page3 reads zero");
        wr(4'h0, 8'h22);
        rd_chk(4'h7, 8'h49, "R11 page3 write ignored status");
        wr(4'h0, 8'hA2);
        rd_chk(4'hF, 8'h02, "R11 page3 write ignored mask");

        repeat (2) @(negedge clk);
        done = 1'b1;
        finish_run();
    end
endmodule